// File: doc/BRIEF.md
# Eight-bit ALU flag generator

This unit computes one of three single-byte operations on an accumulator value and an operand, and produces both the byte result and a fresh condition-flag byte. The three operations are a bitwise exclusive-OR, a compare (a subtraction whose difference only feeds the flags) and an increment of the operand. The flag rules follow a classic eight-bit processor exactly, including two undocumented flag bits that copy bits 3 and 5 from a source that depends on the operation.

A pipeline stage drives the operation code, both data bytes and the current flag byte, and pulses a load strobe. On the next rising clock edge the result and the flags are registered. With the strobe low, or with the reserved operation code, both outputs keep their values. Register-file selection, instruction decoding and memory access are handled by the surrounding logic.

Top module: `alu8_flag_unit`

## Requirements
- R1: An active-low reset (`rst_ni` = 0) clears the result and the flag byte to 0x00 and holds them there while it is asserted.
- R2: Both outputs change only on a rising clock edge where `load_i` is 1 and `op_i` is not 3. With `load_i` at 0, or with `op_i` = 3 (reserved), both outputs hold.
- R3: With `op_i` = 0 (exclusive-OR), the result is `acc_i ^ opnd_i`. Carry (bit 0), subtract (bit 1) and half (bit 4) are cleared. Parity/overflow (bit 2) is 1 when the result has an even number of one bits.
- R4: For exclusive-OR and increment, sign (bit 7) is result bit 7, zero (bit 6) is 1 when the result is 0x00, and flag bits 5 and 3 are copies of result bits 5 and 3.
- R5: With `op_i` = 1 (compare), the registered result is `acc_i` unchanged and subtract (bit 1) is 1. Sign (bit 7) and zero (bit 6) come from the 8-bit difference `acc_i - opnd_i`.
- R6: For compare, half (bit 4) is 1 when the low nibble of `acc_i` is below the low nibble of `opnd_i`. Carry (bit 0) is 1 when `acc_i` is below `opnd_i` as unsigned numbers.
- R7: For compare, parity/overflow (bit 2) is 1 when the signed difference of the two bytes lies outside -128..127.
- R8: For compare, flag bits 5 and 3 are copies of `opnd_i` bits 5 and 3, not of the difference.
- R9: With `op_i` = 2 (increment), the result is `opnd_i + 1` modulo 256. Carry (bit 0) copies `flags_i` bit 0, and subtract (bit 1) is 0. Half (bit 4) is 1 when the operand's low nibble is 0xF. Parity/overflow (bit 2) is 1 exactly when the result is 0x80.
- R10: The flag byte layout, from bit 7 down to bit 0, is sign, zero, copy5, half, copy3, parity/overflow, subtract, carry. `flags_i` bits 7..1 have no effect on any operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe for result and flags |
| op_i | input | 2 | Operation: 0 XOR, 1 compare, 2 increment, 3 reserved (hold) |
| acc_i | input | 8 | Accumulator byte |
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 8 | Current flag byte; only bit 0 is used, by increment |
| result_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered flag byte |

## Verification
The assertions assume that `op_i`, `acc_i`, `opnd_i` and `flags_i` are stable and known whenever `load_i` is sampled high. They also assume that reset is the only other way the registers can change. The stimulus changes every input on the falling clock edge only, so each strobe sees one settled operation. The reserved code appears only in the hold test, where the outputs must not move. For compare and exclusive-OR, every accumulator and operand pair is applied. For increment, every operand is applied with both values of the incoming carry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [1:0] {
      OP_XOR  = 2'd0,
      OP_CMP  = 2'd1,
      OP_INC  = 2'd2,
      OP_RSVD = 2'd3
   } alu_op_e;

   // flag byte, field order is the bit order (MSB first)
   typedef struct packed {
      logic sgn;
      logic zro;
      logic cp5;
      logic hlf;
      logic cp3;
      logic pov;
      logic sub;
      logic cry;
   } flag_t;

   localparam int unsigned NIB_W = 4;

endpackage

// File: rtl/alu8_xor_path.sv
module alu8_xor_path
   import alu8_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o,
   output flag_t             fl_o
);
   logic [DATA_W-1:0] r;

   assign r = a_i ^ b_i;

   always_comb begin
      fl_o     = '0;
      fl_o.sgn = r[DATA_W-1];
      fl_o.zro = (r == '0);
      fl_o.cp5 = r[5];
      fl_o.cp3 = r[3];
      fl_o.pov = ~(^r);
   end

   assign res_o = r;
endmodule

// File: rtl/alu8_cmp_path.sv
module alu8_cmp_path
   import alu8_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o,
   output flag_t             fl_o
);
   localparam int unsigned MSB = DATA_W - 1;

   logic [DATA_W:0]  wide;
   logic [NIB_W:0]   nib;
   logic [MSB:0]     diff;

   assign wide = {1'b0, a_i} - {1'b0, b_i};
   assign nib  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]};
   assign diff = wide[MSB:0];

   always_comb begin
      fl_o     = '0;
      fl_o.sgn = diff[MSB];
      fl_o.zro = (diff == '0);
      fl_o.cp5 = b_i[5];
      fl_o.cp3 = b_i[3];
      fl_o.hlf = nib[NIB_W];
      fl_o.pov = (a_i[MSB] ^ b_i[MSB]) & (diff[MSB] ^ a_i[MSB]);
      fl_o.sub = 1'b1;
      fl_o.cry = wide[DATA_W];
   end

   assign res_o = a_i;
endmodule

// File: rtl/alu8_inc_path.sv
module alu8_inc_path
   import alu8_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] b_i,
   input  logic              cry_i,
   output logic [DATA_W-1:0] res_o,
   output flag_t             fl_o
);
   localparam logic [DATA_W-1:0] SIGN_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] r;

   assign r = b_i + 1'b1;

   always_comb begin
      fl_o     = '0;
      fl_o.sgn = r[DATA_W-1];
      fl_o.zro = (r == '0);
      fl_o.cp5 = r[5];
      fl_o.cp3 = r[3];
      fl_o.hlf = &b_i[NIB_W-1:0];
      fl_o.pov = (r == SIGN_ONLY);
      fl_o.cry = cry_i;
   end

   assign res_o = r;
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
   import alu8_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [7:0]        flags_i,
   output logic [DATA_W-1:0] result_o,
   output logic [7:0]        flags_o
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("alu8_flag_unit: flag layout needs DATA_W == 8");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] x_res, c_res, i_res, nxt_res;
   flag_t             x_fl, c_fl, i_fl, nxt_fl;
   flag_t             cur_fl;
   logic              upd;

   assign op     = alu_op_e'(op_i);
   assign cur_fl = flag_t'(flags_i);

   alu8_xor_path #(.DATA_W(DATA_W)) u_xor (
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .res_o (x_res),
      .fl_o  (x_fl)
   );

   alu8_cmp_path #(.DATA_W(DATA_W)) u_cmp (
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .res_o (c_res),
      .fl_o  (c_fl)
   );

   alu8_inc_path #(.DATA_W(DATA_W)) u_inc (
      .b_i   (opnd_i),
      .cry_i (cur_fl.cry),
      .res_o (i_res),
      .fl_o  (i_fl)
   );

   always_comb begin
      nxt_res = x_res;
      nxt_fl  = x_fl;
      case (op)
         OP_CMP: begin
            nxt_res = c_res;
            nxt_fl  = c_fl;
         end
         OP_INC: begin
            nxt_res = i_res;
            nxt_fl  = i_fl;
         end
         default: begin
            nxt_res = x_res;
            nxt_fl  = x_fl;
         end
      endcase
   end

   assign upd = load_i && (op != OP_RSVD);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         result_o <= '0;
         flags_o  <= '0;
      end else if (upd) begin
         result_o <= nxt_res;
         flags_o  <= nxt_fl;
      end
   end
endmodule

// File: rtl/alu8_flag_chk.sv
module alu8_flag_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       load_i,
   input logic [1:0] op_i,
   input logic [7:0] acc_i,
   input logic [7:0] opnd_i,
   input logic [7:0] flags_i,
   input logic [7:0] result_o,
   input logic [7:0] flags_o
);
   // R2
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i || op_i == 2'd3) |=> ($stable(result_o) && $stable(flags_o)));

   // R3
   xor_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && op_i == 2'd0) |=>
         (result_o == $past(acc_i ^ opnd_i) && !flags_o[0] && !flags_o[1] && !flags_o[4]));

   // R4
   res_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && (op_i == 2'd0 || op_i == 2'd2)) |=>
         (flags_o[6] == (result_o == 8'h00) && flags_o[7] == result_o[7] &&
          flags_o[5] == result_o[5] && flags_o[3] == result_o[3]));

   // R5
   cmp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && op_i == 2'd1) |=> (result_o == $past(acc_i) && flags_o[1]));

   // R8
   cmp_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && op_i == 2'd1) |=>
         (flags_o[5] == $past(opnd_i[5]) && flags_o[3] == $past(opnd_i[3])));

   // R9
   inc_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && op_i == 2'd2) |=>
         (flags_o[0] == $past(flags_i[0]) && !flags_o[1] &&
          result_o == $past(opnd_i + 8'd1)));
endmodule

bind alu8_flag_unit alu8_flag_chk chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .load_i   (load_i),
   .op_i     (op_i),
   .acc_i    (acc_i),
   .opnd_i   (opnd_i),
   .flags_i  (flags_i),
   .result_o (result_o),
   .flags_o  (flags_o)
);

// File: tb/alu8_flag_unit_tb_top.sv
module alu8_flag_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       load_i = 1'b0;
   logic [1:0] op_i = 2'd0;
   logic [7:0] acc_i = 8'd0;
   logic [7:0] opnd_i = 8'd0;
   logic [7:0] flags_i = 8'd0;
   logic [7:0] result_o;
   logic [7:0] flags_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_res = 8'd0;
   logic [7:0] m_flg = 8'd0;

   always #4 clk = ~clk;

   alu8_flag_unit dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .op_i     (op_i),
      .acc_i    (acc_i),
      .opnd_i   (opnd_i),
      .flags_i  (flags_i),
      .result_o (result_o),
      .flags_o  (flags_o)
   );

   // behavioural model: returns {result, flags}
   function automatic logic [15:0] model(int op, int a, int b, int fin);
      int  r, t, ones, sa, sb, sd;
      bit  s, z, y, h, x, p, n, c;
      r = 0; t = 0; ones = 0;
      y = 0; h = 0; x = 0; p = 0; n = 0; c = 0;
      if (op == 0) begin
         r = a ^ b;
         t = r;
         for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
         p = (ones % 2 == 0);
         y = ((r >> 5) & 1) == 1;
         x = ((r >> 3) & 1) == 1;
      end else if (op == 1) begin
         r  = a;
         t  = (a - b) & 255;
         c  = (a < b);
         h  = ((a & 15) < (b & 15));
         sa = (a > 127) ? a - 256 : a;
         sb = (b > 127) ? b - 256 : b;
         sd = sa - sb;
         p  = (sd > 127) || (sd < -128);
         n  = 1;
         y  = ((b >> 5) & 1) == 1;
         x  = ((b >> 3) & 1) == 1;
      end else begin
         r = (b + 1) & 255;
         t = r;
         c = (fin & 1) == 1;
         h = ((b & 15) == 15);
         p = (r == 128);
         y = ((r >> 5) & 1) == 1;
         x = ((r >> 3) & 1) == 1;
      end
      s = (t > 127);
      z = (t == 0);
      model = {r[7:0], s, z, y, h, x, p, n, c};
   endfunction

   task automatic compare(string tag);
      checks++;
      if (result_o !== m_res || flags_o !== m_flg) begin
         errors++;
         $display("FAIL %s got res=%h flg=%h exp res=%h flg=%h",
                  tag, result_o, flags_o, m_res, m_flg);
      end
   endtask

   // called at a falling edge; checks at the next falling edge
   task automatic apply(bit ld, int op, int a, int b, int fin, string tag);
      logic [15:0] e;
      load_i  = ld;
      op_i    = 2'(op);
      acc_i   = 8'(a);
      opnd_i  = 8'(b);
      flags_i = 8'(fin);
      if (ld && op != 3) begin
         e     = model(op, a, b, fin);
         m_res = e[15:8];
         m_flg = e[7:0];
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      // R1: reset holds outputs at zero even with a strobe present
      @(negedge clk);
      load_i = 1'b1; op_i = 2'd2; opnd_i = 8'h41;
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_ni = 1'b1;

      // R3 R4 R10: every pair for exclusive-OR, flags_i bits must not matter
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++)
            apply(1'b1, 0, a, b, (a + b * 3) & 255, "R3 R4 R10 xor");

      // R5 R6 R7 R8 R10: every pair for compare
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b++)
            apply(1'b1, 1, a, b, (a * 5 + b) & 255, "R5 R6 R7 R8 R10 cmp");

      // R9 R4 R10: every operand with both incoming carries
      for (int b = 0; b < 256; b++)
         for (int ci = 0; ci < 2; ci++)
            apply(1'b1, 2, b ^ 8'h5A, b, (ci == 1) ? 8'h01 : 8'hFE, "R9 R4 R10 inc");

      // R9 boundaries: 0x7F -> 0x80 overflow, 0xFF -> 0x00 with carry kept
      apply(1'b1, 2, 0, 8'h7F, 8'h00, "R9 inc 7F");
      apply(1'b1, 2, 0, 8'hFF, 8'h01, "R9 inc FF");

      // R2: strobe low, inputs moving, outputs hold
      apply(1'b1, 1, 8'h10, 8'h20, 0, "R2 setup");
      apply(1'b0, 0, 8'hFF, 8'h00, 0, "R2 hold xor");
      apply(1'b0, 2, 8'h00, 8'h7F, 1, "R2 hold inc");
      // R2: reserved code with strobe high is ignored
      apply(1'b1, 3, 8'hAA, 8'h55, 1, "R2 reserved");
      apply(1'b1, 3, 8'h00, 8'h00, 0, "R2 reserved again");

      // R1: reset in mid-run clears nonzero outputs
      rst_ni = 1'b0;
      load_i = 1'b0;
      m_res = 8'd0;
      m_flg = 8'd0;
      @(negedge clk);
      compare("R1 midrun reset");
      rst_ni = 1'b1;
      apply(1'b1, 0, 8'h0F, 8'hF0, 0, "R3 after reset");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule